// File: doc/BRIEF.md
# Single-Channel Compare Timer

This block is one channel of a memory-mapped system timer. Software programs a 32-bit compare value and a mode bit, then starts or stops the channel by writing to two separate trigger locations. A status bit shows whether the channel is running. A single interrupt output gives a one-cycle pulse for each event.

In interval mode the channel counts down from the compare value and fires periodically. In free-running mode it counts up from zero and fires when the count equals the compare value. The current count can be read at any time. It is reached over a simple synchronous register bus with per-byte write enables. Read data is combinational from the address.

Top module: `chan_timer`

## Requirements
- R1: After reset the compare, counter, status and control reads are all 0 and `irq` is low. The channel is stopped and in interval mode.
- R2: The register map uses byte addresses. Compare is at 0x00 (read/write, byte lane b written when `bus_be[b]` is 1). Counter is at 0x04 (read-only, writes ignored). Status is at 0x10, bit 0 = running. Start is at 0x14 and stop at 0x18; both read as 0. Control is at 0x20, bit 1 = mode, 0 interval and 1 free-running, all other bits read 0.
- R3: A write to 0x14 with `bus_be[0]`=1 and data bit 0 = 1 starts the channel and sets status bit 0 at the write's clock edge. In interval mode the counter takes the compare value; in free-running mode it takes 0.
- R4: A write to 0x18 with `bus_be[0]`=1 and data bit 0 = 1 stops the channel and clears status bit 0. While stopped, the counter holds its value and `irq` stays low.
- R5: A trigger write whose data bit 0 is 0, or whose `bus_be[0]` is 0, has no effect.
- R6: In interval mode with compare value N, the counter decrements once per clock. On the clock after it reads 0, it reloads the compare value and `irq` pulses for one cycle. The first pulse appears N+1 clocks after the start edge, and later pulses repeat every N+1 clocks.
- R7: In free-running mode the counter increments once per clock modulo 2^32. `irq` pulses for one cycle on the clock after the counter equals the latched compare value, so with compare value C the first pulse appears C+1 clocks after the start edge.
- R8: Compare and control writes made while the channel runs are stored at once. The compare value is used at the next reload or start. The mode is used only at the next start.
- R9: Compare values 0xF and 0xFFFFFFFF operate correctly. In interval mode, 0xFFFFFFFF loads in full and counts down from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_be | input | DATA_W/8 (4) | Byte-lane write enables |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| irq | output | 1 | One-cycle event pulse |

## Verification
The main timing function is driven by a table that mixes interval compare values 15, 3 and 1 with free-running compare values 20, 5 and 0. The interval entries measure both the first delay and the repeat gap, which separates an off-by-one in the load from an off-by-one in the reload. The free-running entries show whether the match is taken against the count before or after its increment. The value 0 checks that a match works on the very first count.

Directed cases then cover the following:
- a compare rewrite in the middle of a run, which must change the period only after the next reload;
- a mode change in the middle of a run, which must wait for the next start;
- the full 32-bit load;
- triggers that carry zero data or a disabled byte lane;
- counter hold while stopped.

// File: rtl/chan_timer_pkg.sv
// Package: shared mode type and register byte offsets for the channel timer.
// Assumes byte addressing; offsets are fixed because software decodes them.
package chan_timer_pkg;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_FREE     = 1'b1
    } tmr_mode_e;

    localparam int unsigned OFS_CMP    = 'h00;
    localparam int unsigned OFS_COUNT  = 'h04;
    localparam int unsigned OFS_STATUS = 'h10;
    localparam int unsigned OFS_START  = 'h14;
    localparam int unsigned OFS_STOP   = 'h18;
    localparam int unsigned OFS_CTRL   = 'h20;

    // Bit position of the mode field inside the control register
    localparam int unsigned MODE_BIT   = 1;

endpackage

// File: rtl/chan_timer_regs.sv
// Module: chan_timer_regs
// Register decode for one timer channel. It holds the compare and mode
// registers, turns writes to the trigger addresses into single-cycle
// start/stop strobes, and muxes read data.
// Assumes: DATA_W is a multiple of 8; bus accesses complete in one cycle.
module chan_timer_regs
    import chan_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              run_st,
    output logic [DATA_W-1:0] cmp_q,
    output tmr_mode_e         mode_q,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int NBYTES = DATA_W / 8;

    logic wr_en;
    logic hit_cmp, hit_cnt, hit_stat, hit_ctrl, hit_start, hit_stop;
    logic [7:0] lane_q [NBYTES];

    // Address decode on the full byte address
    always_comb begin
        hit_cmp   = (bus_addr == ADDR_W'(OFS_CMP));
        hit_cnt   = (bus_addr == ADDR_W'(OFS_COUNT));
        hit_stat  = (bus_addr == ADDR_W'(OFS_STATUS));
        hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_start = (bus_addr == ADDR_W'(OFS_START));
        hit_stop  = (bus_addr == ADDR_W'(OFS_STOP));
    end

    assign wr_en = bus_sel && bus_wr;

    // Trigger strobes: need lane 0 enabled and data bit 0 set
    assign start_pulse = wr_en && hit_start && bus_be[0] && bus_wdata[0];
    assign stop_pulse  = wr_en && hit_stop  && bus_be[0] && bus_wdata[0];

    // Compare register: one independently enabled byte per lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // Capture this byte of the compare value on an enabled write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[b] <= '0;
            end else if (wr_en && hit_cmp && bus_be[b]) begin
                lane_q[b] <= bus_wdata[b*8 +: 8];
            end
        end
        assign cmp_q[b*8 +: 8] = lane_q[b];
    end

    // Control register: only the mode bit is stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_INTERVAL;
        end else if (wr_en && hit_ctrl && bus_be[0]) begin
            mode_q <= tmr_mode_e'(bus_wdata[MODE_BIT]);
        end
    end

    // Read mux; trigger and unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (hit_cmp) begin
            bus_rdata = cmp_q;
        end else if (hit_cnt) begin
            bus_rdata = cnt_val;
        end else if (hit_stat) begin
            bus_rdata[0] = run_st;
        end else if (hit_ctrl) begin
            bus_rdata[MODE_BIT] = mode_q;
        end
    end

endmodule

// File: rtl/chan_timer_core.sv
// Module: chan_timer_core
// Counting engine for one timer channel. Interval mode loads the compare
// value and counts down, reloading and pulsing irq after reaching zero.
// Free mode counts up from zero and pulses irq one clock after a match.
// Assumes start and stop strobes are never high in the same cycle.
module chan_timer_core
    import chan_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic             stop_pulse,
    input  logic [CNT_W-1:0] cmp_in,
    input  tmr_mode_e        mode_in,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic [CNT_W-1:0] act_cmp_q,
    output tmr_mode_e        act_mode_q,
    output logic             irq_q
);

    logic cnt_zero;
    logic cnt_match;

    assign cnt_zero  = (cnt_q == '0);
    assign cnt_match = (cnt_q == act_cmp_q);

    // Run state, latched settings, counter and event pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            cnt_q      <= '0;
            act_cmp_q  <= '0;
            act_mode_q <= MODE_INTERVAL;
            irq_q      <= 1'b0;
        end else if (start_pulse) begin
            run_q      <= 1'b1;
            act_cmp_q  <= cmp_in;
            act_mode_q <= mode_in;
            cnt_q      <= (mode_in == MODE_FREE) ? '0 : cmp_in;
            irq_q      <= 1'b0;
        end else if (stop_pulse) begin
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (run_q) begin
            if (act_mode_q == MODE_INTERVAL) begin
                if (cnt_zero) begin
                    cnt_q     <= cmp_in;
                    act_cmp_q <= cmp_in;
                    irq_q     <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                    irq_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
                irq_q <= cnt_match;
            end
        end else begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_timer.sv
// Module: chan_timer (top)
// One memory-mapped timer channel: register decode plus counting engine.
// Assumes a single clock domain and synchronous active-low reset.
module chan_timer
    import chan_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_be,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);

    logic [DATA_W-1:0] cmp_w;
    logic [DATA_W-1:0] cnt_w;
    logic [DATA_W-1:0] act_cmp_w;
    tmr_mode_e         mode_w;
    tmr_mode_e         act_mode_w;
    logic              start_w;
    logic              stop_w;
    logic              run_w;

    chan_timer_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .cnt_val    (cnt_w),
        .run_st     (run_w),
        .cmp_q      (cmp_w),
        .mode_q     (mode_w),
        .start_pulse(start_w),
        .stop_pulse (stop_w),
        .bus_rdata  (bus_rdata)
    );

    chan_timer_core #(
        .CNT_W(DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(start_w),
        .stop_pulse (stop_w),
        .cmp_in     (cmp_w),
        .mode_in    (mode_w),
        .cnt_q      (cnt_w),
        .run_q      (run_w),
        .act_cmp_q  (act_cmp_w),
        .act_mode_q (act_mode_w),
        .irq_q      (irq)
    );

endmodule

// File: rtl/chan_timer_chk.sv
// Module: chan_timer_chk
// Temporal checks on the channel timer, bound into every chan_timer.
module chan_timer_chk
    import chan_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_cmp,
    input tmr_mode_e        act_mode,
    input logic             start_hit,
    input logic             stop_hit
);

    // R3: a start strobe leaves the channel running
    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> run);

    // R4: a stop strobe leaves the channel idle
    p_stop_idles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !run);

    // R4: an idle channel holds its count and raises no event
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start_hit) |=> ($stable(cnt) && !irq));

    // R6: interval counting decrements by one per clock
    p_interval_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_mode == MODE_INTERVAL && cnt != '0 && !start_hit && !stop_hit)
        |=> (cnt == $past(cnt) - 1'b1));

    // R6: reaching zero in interval mode produces an event
    p_interval_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_mode == MODE_INTERVAL && cnt == '0 && !start_hit && !stop_hit)
        |=> irq);

    // R6: an event is a single-cycle pulse unless the period is one clock
    p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && act_cmp != '0) |=> !irq);

    // R7: free counting increments by one per clock, wrapping
    p_free_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_mode == MODE_FREE && !start_hit && !stop_hit)
        |=> (cnt == $past(cnt) + 1'b1));

    // R7: a free-running match produces an event next clock
    p_free_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_mode == MODE_FREE && cnt == act_cmp && !start_hit && !stop_hit)
        |=> irq);

endmodule

bind chan_timer chan_timer_chk #(
    .CNT_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .run      (run_w),
    .cnt      (cnt_w),
    .act_cmp  (act_cmp_w),
    .act_mode (act_mode_w),
    .start_hit(start_w),
    .stop_hit (stop_w)
);

// File: tb/chan_timer_bench.sv
module chan_timer_bench;

    localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STAT = 6'h10;
    localparam logic [5:0] A_GO  = 6'h14, A_HALT = 6'h18, A_CTL = 6'h20;
    localparam int LIMIT = 100;

    // {mode, compare, first-event delay, period (0 = not measured)}
    localparam logic [64:0] VEC [6] = '{
        {1'b0, 32'd15, 16'd16, 16'd16},
        {1'b0, 32'd3,  16'd4,  16'd4},
        {1'b0, 32'd1,  16'd2,  16'd2},
        {1'b1, 32'd20, 16'd21, 16'd0},
        {1'b1, 32'd5,  16'd6,  16'd0},
        {1'b1, 32'd0,  16'd1,  16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        irq;
    int          tests = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    chan_timer u_chan_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_be(be),
        .bus_rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; be = b;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; be = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (!irq && n < LIMIT);
        if (!irq) n = -1;
    endtask

    task automatic idle(input int k);
        repeat (k) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, rd2;
        int n;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(A_CMP, rd);  check("R1", rd, 32'h0);
        bus_read(A_CNT, rd);  check("R1", rd, 32'h0);
        bus_read(A_STAT, rd); check("R1", rd, 32'h0);
        bus_read(A_CTL, rd);  check("R1", rd, 32'h0);
        check("R1", {31'b0, irq}, 32'h0);

        // R2: map, byte lanes, read-only counter, trigger reads
        bus_write(A_CMP, 32'h12345678, 4'hF);
        bus_read(A_CMP, rd); check("R2", rd, 32'h12345678);
        bus_write(A_CMP, 32'hFFFFFFAB, 4'h1);
        bus_read(A_CMP, rd); check("R2", rd, 32'h123456AB);
        bus_write(A_CNT, 32'hDEADBEEF, 4'hF);
        bus_read(A_CNT, rd); check("R2", rd, 32'h0);
        bus_read(A_GO, rd);   check("R2", rd, 32'h0);
        bus_read(A_HALT, rd); check("R2", rd, 32'h0);
        bus_write(A_CTL, 32'hFF, 4'h1);
        bus_read(A_CTL, rd); check("R2", rd, 32'h2);
        bus_write(A_CTL, 32'h0, 4'h1);

        // R5: zero data or disabled lane on a trigger does nothing
        bus_write(A_GO, 32'h0, 4'hF);
        bus_read(A_STAT, rd); check("R5", rd, 32'h0);
        bus_write(A_GO, 32'h1, 4'h0);
        bus_read(A_STAT, rd); check("R5", rd, 32'h0);

        // R6 / R7: vector table
        for (int i = 0; i < 6; i++) begin
            logic [64:0] v;
            string tag;
            v = VEC[i];
            tag = v[64] ? "R7" : "R6";
            bus_write(A_HALT, 32'h1, 4'h1);
            bus_write(A_CMP, v[63:32], 4'hF);
            bus_write(A_CTL, {30'b0, v[64], 1'b0}, 4'h1);
            bus_write(A_GO, 32'h1, 4'h1);
            wait_irq(n);
            check(tag, n, 32'(v[31:16]));
            if (v[15:0] != 0) begin
                wait_irq(n);
                check(tag, n, 32'(v[15:0]));
            end
            idle(1);
            check(tag, {31'b0, irq}, 32'h0);
        end

        // R9 / R3: full-width interval load, then countdown
        bus_write(A_HALT, 32'h1, 4'h1);
        bus_write(A_CTL, 32'h0, 4'h1);
        bus_write(A_CMP, 32'hFFFFFFFF, 4'hF);
        bus_write(A_GO, 32'h1, 4'h1);
        bus_read(A_STAT, rd); check("R3", rd, 32'h1);
        bus_read(A_CNT, rd);  check("R9", rd, 32'hFFFFFFFF);
        idle(3);
        bus_read(A_CNT, rd);  check("R9", rd, 32'hFFFFFFFC);

        // R4: stop clears status, holds count, no event
        bus_write(A_HALT, 32'h1, 4'h1);
        bus_read(A_STAT, rd); check("R4", rd, 32'h0);
        bus_read(A_CNT, rd);
        idle(5);
        bus_read(A_CNT, rd2); check("R4", rd2, rd);
        check("R4", {31'b0, irq}, 32'h0);

        // R7 / R3: free mode starts at zero and counts up
        bus_write(A_CTL, 32'h2, 4'h1);
        bus_write(A_GO, 32'h1, 4'h1);
        bus_read(A_CNT, rd); check("R3", rd, 32'h0);
        idle(5);
        bus_read(A_CNT, rd); check("R7", rd, 32'h5);
        check("R7", {31'b0, irq}, 32'h0);

        // R8: compare rewrite applies at the next reload, mode at next start
        bus_write(A_HALT, 32'h1, 4'h1);
        bus_write(A_CTL, 32'h0, 4'h1);
        bus_write(A_CMP, 32'h7, 4'hF);
        bus_write(A_GO, 32'h1, 4'h1);
        bus_write(A_CMP, 32'h3, 4'hF);
        wait_irq(n); check("R8", n, 32'd7);
        wait_irq(n); check("R8", n, 32'd4);
        bus_write(A_CTL, 32'h2, 4'h1);
        wait_irq(n); check("R8", n, 32'd3);
        bus_write(A_GO, 32'h1, 4'h1);
        bus_read(A_CNT, rd); check("R8", rd, 32'h0);
        idle(2);
        bus_read(A_CNT, rd); check("R8", rd, 32'h2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule